// File: doc/BRIEF.md
# Transport Stream System Time Counter

This block keeps the local system time of a transport stream receiver running from a 27 MHz clock. Its normal form is a mixed-radix count: a 9-bit fraction that steps through 300 states (0 to 299), carrying into a 33-bit base. Together these match the layout of a program clock reference. A mode input turns the block into a plain 33-bit counter that advances on every clock, with the fraction held at zero. Software seeds both fields through a load strobe. It can reload them later, for example when the reference values jump.

When a packet sync strobe arrives, the block copies the 42-bit time {base, fraction} into a snapshot register and pulses a valid flag for one cycle. A receive path uses this to timestamp each packet. Two interrupt sources exist:

- an absolute match against a programmed 42-bit time;
- a repeating elapsed-tick timer.

Each source has a sticky status bit, cleared by a write-1 pulse. A two-word bus read port shows the live time. Reading the low word also latches the high word, so the two halves always belong to the same instant.

Top module: `ts_stc`

## Requirements
- R1: With the mode input low and no load, the fraction field advances by one per clock from 0 to 299 and then returns to 0; it never holds a value above 299.
- R2: The base advances by one on exactly the clock where the fraction goes from 299 to 0, and wraps from all-ones to zero.
- R3: With the mode input high and no load, the base advances by one on every clock and the fraction is forced to 0.
- R4: A load strobe takes priority over counting in the same clock: the base takes the load value, and the fraction takes the load value limited to 299 (or 0 in plain mode).
- R5: A sync strobe at a clock edge captures {base, fraction} as it stood before that edge into the snapshot output, with the valid output high for exactly the following cycle.
- R6: A low-word read returns bits 31:0 of {base, fraction} on the read data output one cycle later and latches bits 41:32. A high-word read returns the latched bits zero-extended. If both strobes are high, the low read wins; otherwise the read data holds.
- R7: When the compare enable is high and {base, fraction} equals the compare time at a clock edge, the absolute status bit is set after that edge and stays set until cleared.
- R8: While the period enable is high, the period status bit is set once every N enabled clocks, where N is the tick count (values 0 and 1 mean every clock). The down-counter reloads itself after each firing and tracks the tick count while the enable is low.
- R9: A clear pulse resets its status bit at the next edge, unless the same edge also sets it, in which case set wins.
- R10: The interrupt output equals the OR of the two status bits.
- R11: After reset the time, snapshot, read data and both status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plain_mode | input | 1 | 1 = base counts every clock, fraction unused |
| ld_en | input | 1 | Load strobe for both time fields |
| ld_base | input | 33 | Base value to load |
| ld_ext | input | 9 | Fraction value to load (limited to 299) |
| pkt_sync | input | 1 | Packet sync strobe, triggers a snapshot |
| snap_valid | output | 1 | One-cycle pulse marking a new snapshot |
| snap_time | output | 42 | Captured {base, fraction} |
| rd_lo | input | 1 | Read strobe for the low word |
| rd_hi | input | 1 | Read strobe for the latched high word |
| rd_data | output | 32 | Registered read data |
| cmp_en | input | 1 | Enables the absolute time match |
| cmp_time | input | 42 | Absolute match time {base, fraction} |
| per_en | input | 1 | Enables the elapsed-tick timer |
| per_ticks | input | 16 | Timer period in clocks |
| clr_abs | input | 1 | Write-1 clear of the absolute status |
| clr_per | input | 1 | Write-1 clear of the period status |
| st_abs | output | 1 | Sticky absolute-match status |
| st_per | output | 1 | Sticky period status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 300-state fraction, a 33-bit base, a 32-bit bus word and a 16-bit tick counter. With these widths, every read splits the 42-bit time across a real word boundary. Directed loads place the time at fraction 299 and at an all-ones base, so the fraction carry and the full base wrap happen within a few cycles instead of after hours. Out-of-range fraction loads exercise the limit to 299. Short tick periods, compare times placed a few ticks ahead of the live time, and random clear pulses make the set-against-clear collisions happen often.

// File: rtl/ts_stc_pkg.sv
package ts_stc_pkg;
   localparam int STC_BASE_W  = 33;
   localparam int STC_EXT_W   = 9;
   localparam int STC_EXT_MOD = 300;
   localparam int STC_BUS_W   = 32;
   localparam int STC_TICK_W  = 16;
endpackage

// File: rtl/ts_stc_core.sv
module ts_stc_core #(
   parameter int BASE_W    = 33,
   parameter int EXT_W     = 9,
   parameter int EXT_MOD   = 300,
   parameter bit HAS_PLAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              plain_mode,
   input  logic              ld_en,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [EXT_W-1:0]  ld_ext,
   output logic [BASE_W-1:0] base_q,
   output logic [EXT_W-1:0]  ext_q,
   output logic              plain_eff
);
   localparam logic [EXT_W-1:0] EXT_MAX = EXT_W'(EXT_MOD - 1);

   generate
      if (HAS_PLAIN) begin : g_plain
         assign plain_eff = plain_mode;
      end else begin : g_noplain
         logic unused_mode;
         assign unused_mode = plain_mode;
         assign plain_eff   = 1'b0;
      end
   endgenerate

   logic              ext_wrap;
   logic [EXT_W-1:0]  ld_ext_lim;
   logic [BASE_W-1:0] base_nx;
   logic [EXT_W-1:0]  ext_nx;

   assign ext_wrap   = (ext_q == EXT_MAX);
   assign ld_ext_lim = (ld_ext > EXT_MAX) ? EXT_MAX : ld_ext;

   always_comb begin
      base_nx = base_q;
      ext_nx  = ext_q;
      if (ld_en) begin
         base_nx = ld_base;
         ext_nx  = plain_eff ? '0 : ld_ext_lim;
      end else if (plain_eff) begin
         base_nx = base_q + 1'b1;
         ext_nx  = '0;
      end else if (ext_wrap) begin
         base_nx = base_q + 1'b1;
         ext_nx  = '0;
      end else begin
         ext_nx  = ext_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         ext_q  <= '0;
      end else begin
         base_q <= base_nx;
         ext_q  <= ext_nx;
      end
   end
endmodule

// File: rtl/ts_stc_event.sv
module ts_stc_event #(
   parameter int TIME_W = 42,
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic              cmp_en,
   input  logic [TIME_W-1:0] cmp_time,
   input  logic              per_en,
   input  logic [TICK_W-1:0] per_ticks,
   input  logic              clr_abs,
   input  logic              clr_per,
   output logic              st_abs,
   output logic              st_per
);
   localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

   logic [TICK_W-1:0] left_q;
   logic              abs_hit;
   logic              per_fire;

   assign abs_hit  = cmp_en && (now == cmp_time);
   assign per_fire = per_en && (left_q <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (!per_en || per_fire) begin
         left_q <= per_ticks;
      end else begin
         left_q <= left_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_abs <= 1'b0;
         st_per <= 1'b0;
      end else begin
         st_abs <= abs_hit  | (st_abs & ~clr_abs);
         st_per <= per_fire | (st_per & ~clr_per);
      end
   end
endmodule

// File: rtl/ts_stc_rdport.sv
module ts_stc_rdport #(
   parameter int TIME_W = 42,
   parameter int BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic              rd_lo,
   input  logic              rd_hi,
   output logic [BUS_W-1:0]  rd_data
);
   localparam int HI_W = TIME_W - BUS_W;

   logic [HI_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q    <= '0;
         rd_data <= '0;
      end else if (rd_lo) begin
         hi_q    <= now[TIME_W-1:BUS_W];
         rd_data <= now[BUS_W-1:0];
      end else if (rd_hi) begin
         rd_data <= {{(BUS_W-HI_W){1'b0}}, hi_q};
      end
   end
endmodule

// File: rtl/ts_stc.sv
module ts_stc
   import ts_stc_pkg::*;
#(
   parameter int BASE_W    = STC_BASE_W,
   parameter int EXT_W     = STC_EXT_W,
   parameter int EXT_MOD   = STC_EXT_MOD,
   parameter int BUS_W     = STC_BUS_W,
   parameter int TICK_W    = STC_TICK_W,
   parameter bit HAS_PLAIN = 1'b1,
   localparam int TIME_W   = BASE_W + EXT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              plain_mode,
   input  logic              ld_en,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [EXT_W-1:0]  ld_ext,
   input  logic              pkt_sync,
   output logic              snap_valid,
   output logic [TIME_W-1:0] snap_time,
   input  logic              rd_lo,
   input  logic              rd_hi,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              cmp_en,
   input  logic [TIME_W-1:0] cmp_time,
   input  logic              per_en,
   input  logic [TICK_W-1:0] per_ticks,
   input  logic              clr_abs,
   input  logic              clr_per,
   output logic              st_abs,
   output logic              st_per,
   output logic              irq
);
   generate
      if (EXT_MOD < 2 || EXT_MOD > (1 << EXT_W)) begin : g_bad_mod
         $error("ts_stc: EXT_MOD does not fit EXT_W");
      end
      if (BUS_W >= TIME_W || 2 * BUS_W < TIME_W) begin : g_bad_bus
         $error("ts_stc: time must span exactly two bus words");
      end
      if (TICK_W < 2) begin : g_bad_tick
         $error("ts_stc: TICK_W too small");
      end
   endgenerate

   logic [BASE_W-1:0] cur_base;
   logic [EXT_W-1:0]  cur_ext;
   logic              plain_eff;
   logic [TIME_W-1:0] now;

   assign now = {cur_base, cur_ext};

   ts_stc_core #(
      .BASE_W(BASE_W), .EXT_W(EXT_W), .EXT_MOD(EXT_MOD), .HAS_PLAIN(HAS_PLAIN)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .plain_mode(plain_mode),
      .ld_en(ld_en), .ld_base(ld_base), .ld_ext(ld_ext),
      .base_q(cur_base), .ext_q(cur_ext), .plain_eff(plain_eff)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_valid <= 1'b0;
         snap_time  <= '0;
      end else begin
         snap_valid <= pkt_sync;
         if (pkt_sync) snap_time <= now;
      end
   end

   ts_stc_rdport #(.TIME_W(TIME_W), .BUS_W(BUS_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .now(now),
      .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
   );

   ts_stc_event #(.TIME_W(TIME_W), .TICK_W(TICK_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .now(now),
      .cmp_en(cmp_en), .cmp_time(cmp_time),
      .per_en(per_en), .per_ticks(per_ticks),
      .clr_abs(clr_abs), .clr_per(clr_per),
      .st_abs(st_abs), .st_per(st_per)
   );

   assign irq = st_abs | st_per;
endmodule

// File: rtl/ts_stc_chk.sv
module ts_stc_chk #(
   parameter int BASE_W  = 33,
   parameter int EXT_W   = 9,
   parameter int EXT_MOD = 300
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BASE_W-1:0] base,
   input logic [EXT_W-1:0]  ext,
   input logic              plain,
   input logic              ld_en,
   input logic [BASE_W-1:0] ld_base,
   input logic [EXT_W-1:0]  ld_ext,
   input logic              sync,
   input logic              snap_valid,
   input logic              st_abs,
   input logic              clr_abs,
   input logic              st_per,
   input logic              clr_per,
   input logic              irq
);
   localparam logic [EXT_W-1:0] EMAX = EXT_W'(EXT_MOD - 1);

   p_ext_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ext <= EMAX);
   p_ext_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !plain && ext != EMAX) |=> ext == EXT_W'($past(ext) + 1'b1));
   p_base_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !plain && ext == EMAX) |=>
         (ext == '0 && base == BASE_W'($past(base) + 1'b1)));
   p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !plain && ext != EMAX) |=> $stable(base));
   p_plain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && plain) |=> (ext == '0 && base == BASE_W'($past(base) + 1'b1)));
   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !plain) |=> (base == $past(ld_base) &&
         ext == (($past(ld_ext) > EMAX) ? EMAX : $past(ld_ext))));
   p_snap_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> snap_valid);
   p_snap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> !snap_valid);
   p_abs_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_abs && !clr_abs) |=> st_abs);
   p_per_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_per && !clr_per) |=> st_per);
   p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (st_abs || st_per));
endmodule

bind ts_stc ts_stc_chk #(.BASE_W(BASE_W), .EXT_W(EXT_W), .EXT_MOD(EXT_MOD)) u_chk (
   .clk(clk), .rst_n(rst_n), .base(cur_base), .ext(cur_ext), .plain(plain_eff),
   .ld_en(ld_en), .ld_base(ld_base), .ld_ext(ld_ext),
   .sync(pkt_sync), .snap_valid(snap_valid),
   .st_abs(st_abs), .clr_abs(clr_abs), .st_per(st_per), .clr_per(clr_per),
   .irq(irq)
);

// File: tb/sim_ts_stc.sv
module sim_ts_stc;
   localparam int PERIOD = 10;
   localparam int BW = 33, EW = 9, TW = 42, BUSW = 32, KW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic plain_mode = 0, ld_en = 0, pkt_sync = 0, rd_lo = 0, rd_hi = 0;
   logic cmp_en = 0, per_en = 0, clr_abs = 0, clr_per = 0;
   logic [BW-1:0] ld_base = '0;
   logic [EW-1:0] ld_ext = '0;
   logic [TW-1:0] cmp_time = '0;
   logic [KW-1:0] per_ticks = '0;
   logic snap_valid, st_abs, st_per, irq;
   logic [TW-1:0] snap_time;
   logic [BUSW-1:0] rd_data;

   always #(PERIOD/2) clk = ~clk;

   ts_stc u0 (
      .clk(clk), .rst_n(rst_n), .plain_mode(plain_mode), .ld_en(ld_en),
      .ld_base(ld_base), .ld_ext(ld_ext), .pkt_sync(pkt_sync),
      .snap_valid(snap_valid), .snap_time(snap_time), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .rd_data(rd_data), .cmp_en(cmp_en), .cmp_time(cmp_time), .per_en(per_en),
      .per_ticks(per_ticks), .clr_abs(clr_abs), .clr_per(clr_per),
      .st_abs(st_abs), .st_per(st_per), .irq(irq)
   );

   // reference model, written from the requirements
   logic [BW-1:0] m_base; logic [EW-1:0] m_ext;
   logic m_sv, m_sa, m_sp; logic [TW-1:0] m_snap;
   logic [BUSW-1:0] m_rd; logic [TW-BUSW-1:0] m_hi; logic [KW-1:0] m_left;

   function automatic logic [EW-1:0] lim_ext(input logic [EW-1:0] v);
      return (v > 9'd299) ? 9'd299 : v;
   endfunction

   always @(posedge clk) begin
      logic [TW-1:0] now;
      logic fire;
      now = {m_base, m_ext};
      if (!rst_n) begin
         m_base <= '0; m_ext <= '0; m_sv <= 0; m_snap <= '0; m_rd <= '0;
         m_hi <= '0; m_sa <= 0; m_sp <= 0; m_left <= '0;
      end else begin
         if (ld_en) begin m_base <= ld_base; m_ext <= plain_mode ? 9'd0 : lim_ext(ld_ext); end
         else if (plain_mode) begin m_base <= m_base + 1; m_ext <= 0; end
         else if (m_ext == 9'd299) begin m_base <= m_base + 1; m_ext <= 0; end
         else m_ext <= m_ext + 1;
         m_sv <= pkt_sync;
         if (pkt_sync) m_snap <= now;
         if (rd_lo) begin m_rd <= now[31:0]; m_hi <= now[41:32]; end
         else if (rd_hi) m_rd <= {22'd0, m_hi};
         fire = per_en && (m_left <= 1);
         m_left <= (!per_en || fire) ? per_ticks : m_left - 1;
         m_sp <= fire | (m_sp & ~clr_per);
         m_sa <= (cmp_en && now == cmp_time) | (m_sa & ~clr_abs);
      end
   end

   int checks = 0, errors = 0;
   bit done = 0;
   string rtag = "R6";

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         if (errors < 20) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
      chk("R5 snap_valid", 64'(snap_valid), 64'(m_sv));
      if (m_sv) chk("R5 snap_time", 64'(snap_time), 64'(m_snap));
      chk({rtag, " rd_data"}, 64'(rd_data), 64'(m_rd));
      chk("R7 st_abs", 64'(st_abs), 64'(m_sa));
      chk("R8 st_per", 64'(st_per), 64'(m_sp));
      chk("R10 irq", 64'(irq), 64'(m_sa | m_sp));
      ld_en = 0; pkt_sync = 0; rd_lo = 0; rd_hi = 0; clr_abs = 0; clr_per = 0;
   endtask

   task automatic load(input logic [BW-1:0] b, input logic [EW-1:0] e);
      ld_base = b; ld_ext = e; ld_en = 1; step();
   endtask

   task automatic rd_both(input string tag);
      rtag = tag; rd_lo = 1; step(); rd_hi = 1; step(); rtag = "R6";
   endtask

   initial begin
      void'($urandom(32'h5eed_0017));
      repeat (3) @(negedge clk);
      // R11: reset values
      chk("R11 rd_data", 64'(rd_data), 0);
      chk("R11 snap_valid", 64'(snap_valid), 0);
      chk("R11 irq", 64'(irq), 0);
      rst_n = 1;
      rd_both("R11");
      // R1 / R2: fraction wrap and carry
      load(33'd5, 9'd298);
      rd_both("R1");
      load(33'd5, 9'd299);
      rtag = "R2"; rd_lo = 1; step(); step(); rtag = "R6";
      // R4: fraction limit on load, load beats counting
      load(33'd77, 9'd450);
      rd_both("R4");
      load(33'd77, 9'd511);
      rd_both("R4");
      // R2: base wrap from all-ones
      load({BW{1'b1}}, 9'd299);
      rd_both("R2");
      // R3: plain mode
      plain_mode = 1; step();
      rd_both("R3"); load(33'h1_0000_0000, 9'd123); rd_both("R3");
      plain_mode = 0; step();
      // R5: snapshot on sync
      pkt_sync = 1; step(); pkt_sync = 1; step(); step();
      // R7/R9: compare with simultaneous clear
      cmp_time = {m_base, m_ext} + 42'd3; cmp_en = 1; step();
      clr_abs = 1; step(); clr_abs = 1; step(); step();
      clr_abs = 1; step();
      // R8: period timer
      per_ticks = 16'd4; per_en = 1;
      repeat (12) begin clr_per = 1; step(); end
      per_ticks = 16'd0; repeat (3) step();
      // random phase
      for (int i = 0; i < 20000; i++) begin
         if ($urandom_range(63) == 0) begin
            ld_en = 1; ld_ext = 9'($urandom);
            ld_base = ($urandom_range(3) == 0) ? {BW{1'b1}} - 33'($urandom_range(3))
                                               : {1'b0, 32'($urandom)};
         end
         if ($urandom_range(255) == 0) plain_mode = ~plain_mode;
         pkt_sync = ($urandom_range(7) == 0);
         rd_lo = ($urandom_range(2) == 0);
         rd_hi = ($urandom_range(3) == 0);
         if ($urandom_range(31) == 0) cmp_time = {m_base, m_ext} + 42'($urandom_range(6));
         cmp_en = ($urandom_range(9) != 0);
         if ($urandom_range(127) == 0) per_ticks = 16'($urandom_range(20));
         per_en = ($urandom_range(15) != 0);
         clr_abs = ($urandom_range(9) == 0);
         clr_per = ($urandom_range(9) == 0);
         step();
      end
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule